// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a narrow 16-bit host bus reach a family of internal registers that sit inside several functional units and may be up to 64 bits wide. The host never addresses those registers directly. It first loads up to four 16-bit staging words. It then writes a single address word that names the unit type, the unit instance, a parameter and a direction. That address write is what launches the internal transfer; writing the staging words on their own does nothing to the internal state.

A write transfer sends all four staging words to the target in one internal access. A read transfer returns one 16-bit slice of the target register, chosen by a read-back index in the address word. The slice lands in staging word 0. To read a wide register, the host repeats the read once per slice. A status register shows a busy flag while a transfer is in flight. The same register holds three host-controlled lines: an active-low global reset, an active-low codec reset and a codec mode select.

Top module: `ixreg_bridge`

## Requirements
- R1: After reset the status, address and all four staging registers read zero, and the outputs `glob_rst_n`, `codec_rst_n` and `codec_quad` are 0.
- R2: Host writes to staging registers (select 4 to 7) only change those registers: busy stays 0 and no `tgt_req` pulse occurs.
- R3: A host write to the address register (select 1) while idle sets busy (status bit 0) from the following clock edge. Busy stays set for exactly 4 cycles and then clears.
- R4: An address write that arrives while busy is ignored. The address register keeps the accepted word and no extra target access occurs.
- R5: Address bits 15:12 (unit type) and 11:8 (instance) select one bit of the one-hot `tgt_sel`. Type 1 with instance 1..6 selects bits 0..5. Type 2 with instance 1..3 selects bits 6..8. Type 3 with instance 1 selects bit 9. Type 9 with instance 1 selects bit 10. Any other combination selects nothing.
- R6: Address bit 7 = 0 is a write. In the last busy cycle `tgt_req` and `tgt_we` are high, `tgt_param` equals address bits 3:2, and `tgt_wdata` is {staging3, staging2, staging1, staging0}.
- R7: Address bit 7 = 1 is a read. When busy clears, staging register 0 holds 16-bit word k (k = address bits 1:0, word 0 = bits 15:0) of `tgt_rdata`.
- R8: An access to an unmatched type or instance completes with normal timing and issues no `tgt_req`. A write is discarded, and a read loads 0 into staging register 0.
- R9: A status write sets codec mode from bit 1, the global reset line from bit 2 and the codec reset line from bit 3. These appear on `codec_quad`, `glob_rst_n` and `codec_rst_n`. Bit 0 of the write is ignored.
- R10: Host select 0 reads status, 1 reads the address register, 4..7 read staging words 0..3, and selects 2 and 3 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_sel | input | 3 | Host register select |
| hb_wen | input | 1 | Host write strobe |
| hb_wdata | input | 16 | Host write data |
| hb_rdata | output | 16 | Host read data, combinational from `hb_sel` |
| tgt_req | output | 1 | Target access strobe, one cycle |
| tgt_we | output | 1 | Target access direction, 1 = write |
| tgt_sel | output | 11 | One-hot target unit select |
| tgt_param | output | 2 | Parameter select within the unit |
| tgt_wdata | output | 64 | Assembled write data |
| tgt_rdata | input | 64 | Read data from the selected target |
| glob_rst_n | output | 1 | Global reset control, active low |
| codec_rst_n | output | 1 | Codec reset control, active low |
| codec_quad | output | 1 | Codec mode select |

## Verification
An address write captured at clock edge E0 shows busy half a cycle later. Busy is still set after edges E1 to E3, and the target strobe is counted at E4. Busy is clear and the read result sits in staging word 0 half a cycle after E4. The bench drives every host write on a falling edge and samples on falling edges counted from E0, so each check lands exactly on the cycle where its result is due. A sweep over all 256 type and instance pairs first writes, then reads back all four words of every pair. Each result is compared with a pattern computed from the pair and the word number, or with zero for unmatched pairs.

// File: rtl/ixb_pkg.sv
package ixb_pkg;

    localparam int HW     = 16;
    localparam int NSTAGE = 4;
    localparam int NTGT   = 11;
    localparam int TIW    = $clog2(NTGT);

    typedef struct packed {
        logic [3:0] utype;
        logic [3:0] inst;
        logic       rd;
        logic [2:0] rsv;
        logic [1:0] param;
        logic [1:0] rbi;
    } xaddr_t;

    typedef struct packed {
        logic           hit;
        logic [TIW-1:0] idx;
    } tsel_t;

    typedef struct packed {
        logic codec_n;
        logic glob_n;
        logic quad;
    } ctl_t;

    localparam logic [2:0] SEL_STAT = 3'd0;
    localparam logic [2:0] SEL_ADDR = 3'd1;

    function automatic tsel_t decode_unit(logic [3:0] ut, logic [3:0] ui);
        tsel_t d;
        d = '0;
        case (ut)
            4'd1: if (ui >= 4'd1 && ui <= 4'd6) begin
                d.hit = 1'b1;
                d.idx = TIW'(ui - 4'd1);
            end
            4'd2: if (ui >= 4'd1 && ui <= 4'd3) begin
                d.hit = 1'b1;
                d.idx = TIW'(ui + 4'd5);
            end
            4'd3: if (ui == 4'd1) begin
                d.hit = 1'b1;
                d.idx = TIW'(9);
            end
            4'd9: if (ui == 4'd1) begin
                d.hit = 1'b1;
                d.idx = TIW'(10);
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ixb_decode.sv
module ixb_decode
    import ixb_pkg::*;
#(
    parameter int NT = NTGT
) (
    input  xaddr_t          addr,
    output logic            hit,
    output logic [NT-1:0]   sel
);
    tsel_t d;

    always_comb d = decode_unit(addr.utype, addr.inst);
    assign hit = d.hit;

    for (genvar g = 0; g < NT; g++) begin : g_sel
        assign sel[g] = d.hit && (d.idx == TIW'(g));
    end
endmodule

// File: rtl/ixb_seq.sv
module ixb_seq #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt_q;

    assign busy   = (cnt_q != '0);
    assign done   = (cnt_q == CW'(1));
    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (accept)
            cnt_q <= CW'(LAT);
        else if (busy)
            cnt_q <= cnt_q - CW'(1);
    end
endmodule

// File: rtl/ixb_stage.sv
module ixb_stage #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   wr_en,
    input  logic [W-1:0]   wdata,
    input  logic           ld0,
    input  logic [W-1:0]   ld0_data,
    output logic [N*W-1:0] words
);
    for (genvar k = 0; k < N; k++) begin : g_word
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (k == 0 && ld0)
                q <= ld0_data;
            else if (wr_en[k])
                q <= wdata;
        end
        assign words[k*W +: W] = q;
    end
endmodule

// File: rtl/ixreg_bridge.sv
module ixreg_bridge
    import ixb_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           hb_sel,
    input  logic                 hb_wen,
    input  logic [HW-1:0]        hb_wdata,
    output logic [HW-1:0]        hb_rdata,
    output logic                 tgt_req,
    output logic                 tgt_we,
    output logic [NTGT-1:0]      tgt_sel,
    output logic [1:0]           tgt_param,
    output logic [NSTAGE*HW-1:0] tgt_wdata,
    input  logic [NSTAGE*HW-1:0] tgt_rdata,
    output logic                 glob_rst_n,
    output logic                 codec_rst_n,
    output logic                 codec_quad
);
    localparam int SW = $clog2(NSTAGE);

    xaddr_t              addr_q;
    ctl_t                ctl_q;
    logic                busy_q;
    logic                done;
    logic                accept;
    logic                hit;
    logic                addr_wr;
    logic [NSTAGE-1:0]   stage_wr;
    logic [HW-1:0]       rd_word;
    logic [NSTAGE*HW-1:0] stage_words;

    assign addr_wr = hb_wen && (hb_sel == SEL_ADDR);

    for (genvar k = 0; k < NSTAGE; k++) begin : g_swr
        assign stage_wr[k] = hb_wen && hb_sel[2] && (hb_sel[SW-1:0] == SW'(k));
    end

    ixb_seq #(.LAT(LAT)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (addr_wr),
        .accept (accept),
        .busy   (busy_q),
        .done   (done)
    );

    ixb_decode #(.NT(NTGT)) u_dec (
        .addr (addr_q),
        .hit  (hit),
        .sel  (tgt_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ctl_q  <= '0;
        end else begin
            if (accept)
                addr_q <= xaddr_t'(hb_wdata);
            if (hb_wen && hb_sel == SEL_STAT)
                ctl_q <= '{codec_n: hb_wdata[3], glob_n: hb_wdata[2], quad: hb_wdata[1]};
        end
    end

    assign rd_word = hit ? tgt_rdata[addr_q.rbi*HW +: HW] : '0;

    ixb_stage #(.W(HW), .N(NSTAGE)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (stage_wr),
        .wdata    (hb_wdata),
        .ld0      (done && addr_q.rd),
        .ld0_data (rd_word),
        .words    (stage_words)
    );

    assign tgt_req   = done && hit;
    assign tgt_we    = !addr_q.rd;
    assign tgt_param = addr_q.param;
    assign tgt_wdata = stage_words;

    assign glob_rst_n  = ctl_q.glob_n;
    assign codec_rst_n = ctl_q.codec_n;
    assign codec_quad  = ctl_q.quad;

    always_comb begin
        hb_rdata = '0;
        if (hb_sel == SEL_STAT)
            hb_rdata = {{(HW-4){1'b0}}, ctl_q.codec_n, ctl_q.glob_n, ctl_q.quad, busy_q};
        else if (hb_sel == SEL_ADDR)
            hb_rdata = addr_q;
        else if (hb_sel[2])
            hb_rdata = stage_words[hb_sel[SW-1:0]*HW +: HW];
    end
endmodule

// File: rtl/ixb_checker.sv
module ixb_checker #(
    parameter int NT  = 11,
    parameter int LAT = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    hb_sel,
    input logic          hb_wen,
    input logic          busy_q,
    input logic          tgt_req,
    input logic [NT-1:0] tgt_sel,
    input logic          glob_rst_n,
    input logic          codec_rst_n,
    input logic          codec_quad
);
    localparam int LW = $clog2(LAT + 1) + 1;
    logic [LW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (busy_q)
            run_q <= run_q + LW'(1);
        else
            run_q <= '0;
    end

    assert_busy_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(hb_wen && hb_sel == 3'd1));

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (run_q < LW'(LAT)));

    assert_busy_end_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> (run_q == LW'(LAT)));

    assert_no_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !(hb_wen && hb_sel == 3'd1)) |=> !busy_q);

    assert_req_last_R6: assert property (@(posedge clk) disable iff (rst)
        tgt_req |-> busy_q ##1 !busy_q);

    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tgt_sel));

    assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(hb_wen && hb_sel == 3'd0) |=> $stable({glob_rst_n, codec_rst_n, codec_quad}));
endmodule

bind ixreg_bridge ixb_checker #(.NT(ixb_pkg::NTGT), .LAT(LAT)) u_chk (.*);

// File: tb/test_ixreg_bridge.sv
module test_ixreg_bridge;
    logic        clk = 0;
    logic        rst;
    logic [2:0]  hb_sel;
    logic        hb_wen;
    logic [15:0] hb_wdata;
    logic [15:0] hb_rdata;
    logic        tgt_req, tgt_we;
    logic [10:0] tgt_sel;
    logic [1:0]  tgt_param;
    logic [63:0] tgt_wdata;
    logic [63:0] tgt_rdata;
    logic        glob_rst_n, codec_rst_n, codec_quad;

    int n_chk = 0;
    int n_bad = 0;
    int req_cnt = 0;
    bit finished = 0;

    logic [63:0] mem [11][4];

    always #5 clk = ~clk;

    ixreg_bridge i_ixreg_bridge (.*);

    always_comb begin
        tgt_rdata = '0;
        for (int j = 0; j < 11; j++)
            if (tgt_sel[j]) tgt_rdata = mem[j][tgt_param];
    end

    always @(posedge clk) begin
        if (tgt_req) begin
            req_cnt <= req_cnt + 1;
            if (tgt_we)
                for (int j = 0; j < 11; j++)
                    if (tgt_sel[j]) mem[j][tgt_param] <= tgt_wdata;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(logic [2:0] s, logic [15:0] d);
        @(negedge clk);
        hb_sel = s; hb_wen = 1'b1; hb_wdata = d;
        @(negedge clk);
        hb_wen = 1'b0;
    endtask

    task automatic host_read(logic [2:0] s, output logic [15:0] r);
        hb_sel = s;
        #1;
        r = hb_rdata;
    endtask

    task automatic xact(logic [15:0] a);
        host_write(3'd1, a);
        repeat (4) @(negedge clk);
    endtask

    function automatic int exp_idx(int t, int i);
        if (t == 1 && i >= 1 && i <= 6) return i - 1;
        if (t == 2 && i >= 1 && i <= 3) return i + 5;
        if (t == 3 && i == 1) return 9;
        if (t == 9 && i == 1) return 10;
        return -1;
    endfunction

    function automatic logic [15:0] pat(int t, int i, int k);
        return {4'(t), 4'(i), 4'(k), 4'(t + i) ^ 4'hC};
    endfunction

    function automatic logic [15:0] mk_addr(int t, int i, bit rd, int p, int k);
        return {4'(t), 4'(i), rd, 3'b000, 2'(p), 2'(k)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int base;
        for (int j = 0; j < 11; j++)
            for (int p = 0; p < 4; p++) mem[j][p] = '0;
        rst = 1; hb_sel = 0; hb_wen = 0; hb_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state, R10 map
        host_read(3'd0, r); chk("R1 status", r, 16'h0);
        host_read(3'd1, r); chk("R1 address", r, 16'h0);
        for (int k = 0; k < 4; k++) begin
            host_read(3'(4 + k), r); chk("R1 staging", r, 16'h0);
        end
        chk("R1 ctl outputs", {glob_rst_n, codec_rst_n, codec_quad}, 3'b000);
        host_read(3'd2, r); chk("R10 select2 zero", r, 16'h0);

        // R9 control bits
        host_write(3'd0, 16'hFFFF);
        host_read(3'd0, r); chk("R9 status all", r, 16'h000E);
        chk("R9 outputs all", {glob_rst_n, codec_rst_n, codec_quad}, 3'b111);
        host_write(3'd0, 16'h0005);
        host_read(3'd0, r); chk("R9 status glob only", r, 16'h0004);
        chk("R9 outputs glob only", {glob_rst_n, codec_rst_n, codec_quad}, 3'b100);

        // R2 staging writes alone
        base = req_cnt;
        for (int k = 0; k < 4; k++) host_write(3'(4 + k), 16'h1111 * (k + 1));
        repeat (3) @(negedge clk);
        host_read(3'd0, r); chk("R2 busy stays 0", r[0], 1'b0);
        chk("R2 no target request", req_cnt, base);
        for (int k = 0; k < 4; k++) begin
            host_read(3'(4 + k), r); chk("R10 staging readback", r, 16'h1111 * (k + 1));
        end
        host_read(3'd3, r); chk("R10 select3 zero", r, 16'h0);

        // R3 timing, R6 write data and param
        base = req_cnt;
        host_write(3'd1, mk_addr(2, 1, 0, 2, 0));
        host_read(3'd0, r); chk("R3 busy after E0", r[0], 1'b1);
        for (int n = 1; n < 4; n++) begin
            @(negedge clk);
            host_read(3'd0, r); chk("R3 busy held", r[0], 1'b1);
        end
        @(negedge clk);
        host_read(3'd0, r); chk("R3 busy cleared", r[0], 1'b0);
        chk("R6 one request", req_cnt, base + 1);
        chk("R6 assembled data", mem[6][2], 64'h4444_3333_2222_1111);

        // R4 address write while busy
        base = req_cnt;
        host_write(3'd1, mk_addr(3, 1, 0, 1, 0));
        host_write(3'd1, mk_addr(9, 1, 0, 3, 0));
        repeat (3) @(negedge clk);
        host_read(3'd0, r); chk("R4 idle after first", r[0], 1'b0);
        host_read(3'd1, r); chk("R4 address kept", r, mk_addr(3, 1, 0, 1, 0));
        chk("R4 single request", req_cnt, base + 1);
        chk("R4 second discarded", mem[10][3], 64'h0);

        // R5 R6 R8 write sweep
        for (int t = 0; t < 16; t++)
            for (int i = 0; i < 16; i++) begin
                int e;
                e = exp_idx(t, i);
                for (int k = 0; k < 4; k++) host_write(3'(4 + k), pat(t, i, k));
                base = req_cnt;
                xact(mk_addr(t, i, 0, (t + i) % 4, 0));
                chk("R5 target select", tgt_sel, (e < 0) ? 11'd0 : (11'd1 << e));
                chk("R8 request only on match", req_cnt, base + ((e < 0) ? 0 : 1));
            end

        // R7 R8 read sweep
        for (int t = 0; t < 16; t++)
            for (int i = 0; i < 16; i++)
                for (int k = 0; k < 4; k++) begin
                    int e;
                    e = exp_idx(t, i);
                    host_write(3'd4, 16'hDEAD);
                    xact(mk_addr(t, i, 1, (t + i) % 4, k));
                    host_read(3'd4, r);
                    chk((e < 0) ? "R8 unmatched read zero" : "R7 read word", r,
                        (e < 0) ? 16'h0 : pat(t, i, k));
                end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule